// File: doc/BRIEF.md
# One-Time Fuse Array Controller

A bus-attached controller in front of a one-time-programmable fuse array. The array is split into banks of eight-bit words. Each word has a shadow copy that software reads and may overwrite (override). Two timed operations work on the physical fuses. An explicit sense copies one word's fuse value into a sense data register. A program cycle blows exactly one fuse bit, and it runs only when a protection key has been written beforehand.

Control and status are reached through a single-cycle register bus. Read data returns one cycle after the request. The fuse model starts blank at reset and can only ever gain set bits. Each shadow word starts as a copy of the blank array and is refreshed from the fuse value after every successful program cycle. Read, write and override protection are fixed per bank by parameters. The program and sense cycle lengths are parameters too.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, status, error, sense data, key, address and control registers all read 0, and every shadow word reads 0.
- R2: Bus map: addr[11]=1 selects shadow word {bank=addr[10:8], word=addr[7:0]}. addr[11]=0 selects registers by offset: 0 status, 1 status mask, 2 error, 3 error mask, 4 control, 5 upper address, 6 lower address, 7 sense data, 8 key. A read request sets rvalid_o and rdata_o on the next cycle. A write to an unprotected shadow word replaces its value.
- R3: A shadow write to an override-protected bank leaves the word unchanged and sets error bit 5.
- R4: A shadow read from a read-protected bank returns 0 and sets error bit 4.
- R5: Control bit 0 starts a program cycle when the key register holds 0xAA. The target is bank = upper[5:3], word = {upper[2:0], lower[7:3]}, bit = lower[2:0]. Status bit 7 (busy) reads 1 for exactly PRG_CYCLES consecutive cycles. After that, status bit 1 is set and the shadow word equals the fuse word.
- R6: A program request while the key is not 0xAA starts no cycle, sets error bit 7 and leaves the fuses unchanged.
- R7: A keyed program request on a write-protected bank starts no cycle, sets error bit 6 and leaves status bit 1 clear.
- R8: Control bit 3 (with bit 0 clear) starts a sense. Busy reads 1 for exactly SNS_CYCLES cycles. After that, status bit 0 is set and sense data holds the physical fuse word, unaffected by shadow overrides.
- R9: A sense request on a read-protected bank starts no cycle and sets error bit 2.
- R10: While busy, writes to the control and address registers are ignored. A program request made while busy also sets error bit 7.
- R11: Status bits 1:0 and error bits 7:1 are write-1-to-clear. Writing 0 to a bit leaves it unchanged.
- R12: Fuse bits are only ever set. Programming another bit of a word ORs it into the existing value.
- R13: Status mask keeps bits 1:0, error mask keeps bits 7:1, and control keeps bits 7:4. The pulse-length and compare-disable fields do not change the cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (12) | Register offset or shadow word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |

## Verification
Every read result appears on the cycle after the edge that samples the request. The bench reads it at the following falling edge. A program or sense cycle shows busy from the first read sampled after the control write. The bench holds back-to-back status reads from that cycle on and counts the busy reads, so the count must equal PRG_CYCLES or SNS_CYCLES exactly, and the first non-busy read must already carry the done flag. A rejected request changes nothing but its error bit. That is checked with the next status and error reads, and with a read of the target shadow word.

// File: rtl/otp_fuse_pkg.sv
`timescale 1ns/1ps
package otp_fuse_pkg;

  typedef enum logic [3:0] {
    REG_STAT  = 4'd0,
    REG_STATM = 4'd1,
    REG_ERR   = 4'd2,
    REG_EMASK = 4'd3,
    REG_FCTL  = 4'd4,
    REG_UADDR = 4'd5,
    REG_LADDR = 4'd6,
    REG_SDATA = 4'd7,
    REG_KEY   = 4'd8
  } reg_id_e;

  typedef enum logic [1:0] {OP_IDLE, OP_PRG, OP_SNS} op_e;

  localparam int unsigned ST_BUSY  = 7;
  localparam int unsigned ST_PDONE = 1;
  localparam int unsigned ST_SDONE = 0;

  localparam int unsigned ER_PRG = 7;
  localparam int unsigned ER_WP  = 6;
  localparam int unsigned ER_OVR = 5;
  localparam int unsigned ER_RD  = 4;
  localparam int unsigned ER_SNS = 2;

  localparam int unsigned FC_PRG = 0;
  localparam int unsigned FC_SNS = 3;

  localparam logic [7:0] PRG_KEY = 8'hAA;

endpackage

// File: rtl/fuse_bank.sv
`timescale 1ns/1ps
module fuse_bank #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] sh_addr_i,
  input  logic          sh_we_i,
  input  logic [7:0]    sh_wdata_i,
  output logic [7:0]    sh_rdata_o,
  input  logic [AW-1:0] op_addr_i,
  input  logic [2:0]    op_bit_i,
  input  logic          blow_i,
  output logic [7:0]    fuse_rdata_o
);

  logic [7:0] shadow_q [WORDS];
  logic [7:0] fuse_q   [WORDS];
  logic [7:0] blown;

  assign blown        = fuse_q[op_addr_i] | (8'd1 << op_bit_i);
  assign sh_rdata_o   = shadow_q[sh_addr_i];
  assign fuse_rdata_o = fuse_q[op_addr_i];

  // blank array at reset; shadow mirrors it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) begin
        shadow_q[i] <= '0;
        fuse_q[i]   <= '0;
      end
    end else begin
      if (sh_we_i) shadow_q[sh_addr_i] <= sh_wdata_i;
      // refresh after blow wins over a same-cycle override
      if (blow_i) begin
        fuse_q[op_addr_i]   <= blown;
        shadow_q[op_addr_i] <= blown;
      end
    end
  end

endmodule

// File: rtl/fuse_timer.sv
`timescale 1ns/1ps
module fuse_timer
  import otp_fuse_pkg::*;
#(
  parameter int unsigned PRG_CYCLES = 200,
  parameter int unsigned SNS_CYCLES = 20,
  localparam int unsigned MAX_CYC = (PRG_CYCLES > SNS_CYCLES) ? PRG_CYCLES : SNS_CYCLES,
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prg_start_i,
  input  logic sns_start_i,
  output logic busy_o,
  output logic prg_run_o,
  output logic sns_run_o,
  output logic prg_done_o,
  output logic sns_done_o
);

  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last       = (cnt_q == '0);
  assign prg_run_o  = (op_q == OP_PRG);
  assign sns_run_o  = (op_q == OP_SNS);
  assign busy_o     = prg_run_o | sns_run_o;
  assign prg_done_o = prg_run_o & last;
  assign sns_done_o = sns_run_o & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (op_q == OP_IDLE) begin
      if (prg_start_i) begin
        op_q  <= OP_PRG;
        cnt_q <= CNT_W'(PRG_CYCLES - 1);
      end else if (sns_start_i) begin
        op_q  <= OP_SNS;
        cnt_q <= CNT_W'(SNS_CYCLES - 1);
      end
    end else if (last) begin
      op_q <= OP_IDLE;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/otp_fuse_ctrl.sv
`timescale 1ns/1ps
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned NUM_BANKS      = 8,
  parameter int unsigned WORDS_PER_BANK = 256,
  parameter int unsigned PRG_CYCLES     = 200,
  parameter int unsigned SNS_CYCLES     = 20,
  parameter logic [NUM_BANKS-1:0] RD_PROT  = '0,
  parameter logic [NUM_BANKS-1:0] WR_PROT  = '0,
  parameter logic [NUM_BANKS-1:0] OVR_PROT = '0,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned WORD_W = $clog2(WORDS_PER_BANK),
  localparam int unsigned ADDR_W = 1 + 3 + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              rvalid_o
);

  // bus decode
  logic              rd, wr, sel_shadow, reg_hit, reg_wr;
  logic [BANK_W-1:0] acc_bank;
  logic [WORD_W-1:0] acc_word;
  reg_id_e           reg_id;

  assign rd         = req_i & ~we_i;
  assign wr         = req_i & we_i;
  assign sel_shadow = addr_i[ADDR_W-1];
  assign acc_bank   = addr_i[8 +: BANK_W];
  assign acc_word   = addr_i[WORD_W-1:0];
  assign reg_id     = reg_id_e'(addr_i[3:0]);
  assign reg_hit    = ~sel_shadow & (addr_i[ADDR_W-2:4] == '0);
  assign reg_wr     = wr & reg_hit;

  // registers
  logic [1:0] stat_q, statm_q;
  logic [7:1] err_q, emask_q;
  logic [7:4] fctl_q;
  logic [5:0] ua_q;
  logic [7:0] la_q, sdat_q, key_q;

  // fuse operation target
  logic [7:0]        op_row;
  logic [WORD_W-1:0] op_word;
  logic [BANK_W-1:0] op_bank;

  assign op_row  = {ua_q[2:0], la_q[7:3]};
  assign op_word = op_row[WORD_W-1:0];
  assign op_bank = ua_q[3 +: BANK_W];

  // timer
  logic busy, prg_run, sns_run, prg_done, sns_done;
  logic fctl_wr, prg_req, sns_req, key_ok;
  logic prg_go, prg_bad, prg_wp, sns_go, sns_err;

  assign fctl_wr = reg_wr & (reg_id == REG_FCTL);
  assign prg_req = fctl_wr & wdata_i[FC_PRG];
  assign sns_req = fctl_wr & wdata_i[FC_SNS] & ~wdata_i[FC_PRG];
  assign key_ok  = (key_q == PRG_KEY);
  assign prg_bad = prg_req & (busy | ~key_ok);
  assign prg_wp  = prg_req & ~busy & key_ok & WR_PROT[op_bank];
  assign prg_go  = prg_req & ~busy & key_ok & ~WR_PROT[op_bank];
  assign sns_err = sns_req & ~busy & RD_PROT[op_bank];
  assign sns_go  = sns_req & ~busy & ~RD_PROT[op_bank];

  fuse_timer #(
    .PRG_CYCLES(PRG_CYCLES),
    .SNS_CYCLES(SNS_CYCLES)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prg_start_i(prg_go),
    .sns_start_i(sns_go),
    .busy_o     (busy),
    .prg_run_o  (prg_run),
    .sns_run_o  (sns_run),
    .prg_done_o (prg_done),
    .sns_done_o (sns_done)
  );

  // shadow access
  logic ovr_wr, ovr_ok, ovr_err, rd_err;
  assign ovr_wr  = wr & sel_shadow;
  assign ovr_ok  = ovr_wr & ~OVR_PROT[acc_bank];
  assign ovr_err = ovr_wr & OVR_PROT[acc_bank];
  assign rd_err  = rd & sel_shadow & RD_PROT[acc_bank];

  logic [7:0] sh_rd [NUM_BANKS];
  logic [7:0] fz_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fuse_bank #(.WORDS(WORDS_PER_BANK)) i_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sh_addr_i   (acc_word),
      .sh_we_i     (ovr_ok & (acc_bank == BANK_W'(b))),
      .sh_wdata_i  (wdata_i),
      .sh_rdata_o  (sh_rd[b]),
      .op_addr_i   (op_word),
      .op_bit_i    (la_q[2:0]),
      .blow_i      (prg_done & (op_bank == BANK_W'(b))),
      .fuse_rdata_o(fz_rd[b])
    );
  end

  // status / error: set wins over clear
  logic [1:0] stat_clr, stat_set;
  logic [7:1] err_clr, err_set;
  logic       err_wr;

  assign err_wr   = reg_wr & (reg_id == REG_ERR);
  assign stat_clr = (reg_wr & (reg_id == REG_STAT)) ? wdata_i[1:0] : 2'b00;
  assign err_clr  = err_wr ? wdata_i[7:1] : 7'd0;
  assign stat_set = {prg_done, sns_done};

  always_comb begin
    err_set         = '0;
    err_set[ER_PRG] = prg_bad;
    err_set[ER_WP]  = prg_wp;
    err_set[ER_OVR] = ovr_err;
    err_set[ER_RD]  = rd_err;
    err_set[ER_SNS] = sns_err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      statm_q <= '0;
      err_q   <= '0;
      emask_q <= '0;
      fctl_q  <= '0;
      ua_q    <= '0;
      la_q    <= '0;
      sdat_q  <= '0;
      key_q   <= '0;
    end else begin
      stat_q <= (stat_q & ~stat_clr) | stat_set;
      err_q  <= (err_q & ~err_clr) | err_set;
      if (sns_done) sdat_q <= fz_rd[op_bank];
      if (reg_wr) begin
        unique case (reg_id)
          REG_STATM: statm_q <= wdata_i[1:0];
          REG_EMASK: emask_q <= wdata_i[7:1];
          REG_KEY:   key_q   <= wdata_i;
          REG_FCTL:  if (!busy) fctl_q <= wdata_i[7:4];
          REG_UADDR: if (!busy) ua_q   <= wdata_i[5:0];
          REG_LADDR: if (!busy) la_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  // read path
  logic [7:0] reg_rd, rd_mux;

  always_comb begin
    reg_rd = '0;
    if (reg_hit) begin
      unique case (reg_id)
        REG_STAT:  reg_rd = {busy, 5'd0, stat_q};
        REG_STATM: reg_rd = {6'd0, statm_q};
        REG_ERR:   reg_rd = {err_q, 1'b0};
        REG_EMASK: reg_rd = {emask_q, 1'b0};
        REG_FCTL:  reg_rd = {fctl_q, sns_run, 2'b00, prg_run};
        REG_UADDR: reg_rd = {2'b00, ua_q};
        REG_LADDR: reg_rd = la_q;
        REG_SDATA: reg_rd = sdat_q;
        REG_KEY:   reg_rd = key_q;
        default:   reg_rd = '0;
      endcase
    end
  end

  assign rd_mux = sel_shadow ? (RD_PROT[acc_bank] ? 8'd0 : sh_rd[acc_bank]) : reg_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_mux;
    end
  end

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
`timescale 1ns/1ps
module otp_fuse_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic       rvalid_o,
  input logic       busy,
  input logic       prg_run,
  input logic [1:0] stat_q,
  input logic [7:1] err_q,
  input logic [7:0] key_q,
  input logic       err_wr
);

  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i |=> rvalid_o);

  // R2
  no_stray_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);

  // R11
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_wr |=> ((err_q & $past(err_q)) == $past(err_q)));

  // R5
  prg_done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[1]) |-> $fell(busy));

  // R8
  sns_done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q[0]) |-> $fell(busy));

  // R6
  prg_keyed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prg_run) |-> ($past(key_q) == 8'hAA));

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .rvalid_o(rvalid_o),
  .busy    (busy),
  .prg_run (prg_run),
  .stat_q  (stat_q),
  .err_q   (err_q),
  .key_q   (key_q),
  .err_wr  (err_wr)
);

// File: tb/test_otp_fuse_ctrl.sv
`timescale 1ns/1ps
module test_otp_fuse_ctrl;

  localparam int PRG_N = 12;
  localparam int SNS_N = 5;

  localparam logic [11:0] A_STAT  = 12'h000;
  localparam logic [11:0] A_STATM = 12'h001;
  localparam logic [11:0] A_ERR   = 12'h002;
  localparam logic [11:0] A_EMASK = 12'h003;
  localparam logic [11:0] A_FCTL  = 12'h004;
  localparam logic [11:0] A_UA    = 12'h005;
  localparam logic [11:0] A_LA    = 12'h006;
  localparam logic [11:0] A_SDAT  = 12'h007;
  localparam logic [11:0] A_KEY   = 12'h008;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        rvalid_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  otp_fuse_ctrl #(
    .NUM_BANKS(8), .WORDS_PER_BANK(256),
    .PRG_CYCLES(PRG_N), .SNS_CYCLES(SNS_N),
    .RD_PROT(8'h80), .WR_PROT(8'h40), .OVR_PROT(8'h20)
  ) i_otp_fuse_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [11:0] sh(input int bank, input int word);
    return {1'b1, 3'(bank), 8'(word)};
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d, output logic v);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    d = rdata_o; v = rvalid_o;
    req_i = 1'b0;
  endtask

  task automatic expect_rd(input logic [11:0] a, input logic [7:0] exp, input string r);
    logic [7:0] d; logic v;
    bus_rd(a, d, v);
    chk(v && d == exp, r, {v, d}, {1'b1, exp});
  endtask

  task automatic set_addr(input int bank, input int word, input int bitn);
    bus_wr(A_UA, 8'((bank << 3) | (word >> 5)));
    bus_wr(A_LA, 8'(((word << 3) | bitn) & 8'hFF));
  endtask

  // fctl write then back-to-back status reads; counts busy reads
  task automatic run_op(input logic [7:0] fc, output int n, output logic [7:0] st);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = A_FCTL; wdata_i = fc;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = A_STAT; n = 0; st = 8'hFF;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk_i);
      if (rdata_o[7]) n++;
      else begin st = rdata_o; break; end
    end
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    expect_rd(A_STAT, 8'h00, "R1 stat");
    expect_rd(A_ERR, 8'h00, "R1 err");
    expect_rd(A_KEY, 8'h00, "R1 key");
    expect_rd(A_SDAT, 8'h00, "R1 sdat");
    expect_rd(A_FCTL, 8'h00, "R1 fctl");
    expect_rd(sh(3, 200), 8'h00, "R1 shadow");
  endtask

  task automatic t_override;
    bus_wr(sh(1, 8'h21), 8'h5A);
    expect_rd(sh(1, 8'h21), 8'h5A, "R2 override readback");
    expect_rd(sh(1, 8'h22), 8'h00, "R2 neighbour untouched");
    expect_rd(A_ERR, 8'h00, "R2 no error");
  endtask

  task automatic t_ovr_prot;
    bus_wr(sh(5, 3), 8'hFF);
    expect_rd(sh(5, 3), 8'h00, "R3 protected word unchanged");
    expect_rd(A_ERR, 8'h20, "R3 override error");
    bus_wr(A_ERR, 8'h20);
  endtask

  task automatic t_rd_prot;
    expect_rd(sh(7, 0), 8'h00, "R4 protected read zero");
    expect_rd(A_ERR, 8'h10, "R4 read error");
    bus_wr(A_ERR, 8'h10);
  endtask

  task automatic t_w1c;
    logic [7:0] d; logic v;
    bus_wr(sh(5, 0), 8'h01);
    bus_rd(sh(7, 1), d, v);
    expect_rd(A_ERR, 8'h30, "R11 two errors set");
    bus_wr(A_ERR, 8'h00);
    expect_rd(A_ERR, 8'h30, "R11 zero write keeps");
    bus_wr(A_ERR, 8'h10);
    expect_rd(A_ERR, 8'h20, "R11 clears one bit");
    bus_wr(A_ERR, 8'h20);
    expect_rd(A_ERR, 8'h00, "R11 cleared");
  endtask

  task automatic t_program;
    int n; logic [7:0] st;
    bus_wr(sh(2, 8'h47), 8'h03);
    bus_wr(A_KEY, 8'hAA);
    set_addr(2, 8'h47, 5);
    expect_rd(A_UA, 8'h12, "R5 upper encoding");
    expect_rd(A_LA, 8'h3D, "R5 lower encoding");
    run_op(8'h01, n, st);
    chk(n == PRG_N, "R5 busy cycles", n, PRG_N);
    chk(st == 8'h02, "R5 program done", st, 8'h02);
    expect_rd(sh(2, 8'h47), 8'h20, "R5 shadow refreshed");
    expect_rd(A_ERR, 8'h00, "R5 no error");
    bus_wr(A_STAT, 8'h00);
    expect_rd(A_STAT, 8'h02, "R11 stat zero write keeps");
    bus_wr(A_STAT, 8'h02);
    expect_rd(A_STAT, 8'h00, "R11 stat cleared");
    set_addr(2, 8'h47, 0);
    run_op(8'h01, n, st);
    expect_rd(sh(2, 8'h47), 8'h21, "R12 bits accumulate");
    bus_wr(A_STAT, 8'h02);
    bus_wr(A_KEY, 8'h00);
  endtask

  task automatic t_sense;
    int n; logic [7:0] st;
    bus_wr(sh(2, 8'h47), 8'hEE);
    run_op(8'h08, n, st);
    chk(n == SNS_N, "R8 busy cycles", n, SNS_N);
    chk(st == 8'h01, "R8 sense done", st, 8'h01);
    expect_rd(A_SDAT, 8'h21, "R8 sense data is fuse value");
    bus_wr(A_STAT, 8'h01);
  endtask

  task automatic t_nokey;
    set_addr(3, 1, 0);
    bus_wr(A_FCTL, 8'h01);
    expect_rd(A_STAT, 8'h00, "R6 no cycle started");
    expect_rd(A_ERR, 8'h80, "R6 program error");
    expect_rd(sh(3, 1), 8'h00, "R6 fuse unchanged");
    bus_wr(A_ERR, 8'h80);
  endtask

  task automatic t_wprot;
    bus_wr(A_KEY, 8'hAA);
    set_addr(6, 9, 2);
    bus_wr(A_FCTL, 8'h01);
    expect_rd(A_STAT, 8'h00, "R7 no cycle, no done");
    expect_rd(A_ERR, 8'h40, "R7 write protect error");
    bus_wr(A_ERR, 8'h40);
    bus_wr(A_KEY, 8'h00);
  endtask

  task automatic t_sns_prot;
    set_addr(7, 4, 0);
    bus_wr(A_FCTL, 8'h08);
    expect_rd(A_STAT, 8'h00, "R9 no sense cycle");
    expect_rd(A_ERR, 8'h04, "R9 sense error");
    bus_wr(A_ERR, 8'h04);
  endtask

  task automatic t_busy;
    logic [7:0] d; logic v;
    bus_wr(A_KEY, 8'hAA);
    set_addr(4, 8'h10, 1);
    bus_wr(A_FCTL, 8'h01);
    bus_wr(A_UA, 8'h3F);
    bus_wr(A_FCTL, 8'h01);
    bus_wr(A_FCTL, 8'h08);
    d = 8'h80;
    for (int k = 0; k < 50 && d[7]; k++) bus_rd(A_STAT, d, v);
    chk(d == 8'h02, "R10 only first op ran", d, 8'h02);
    expect_rd(A_UA, 8'h20, "R10 address write ignored");
    expect_rd(A_ERR, 8'h80, "R10 busy program error");
    expect_rd(sh(4, 8'h10), 8'h02, "R10 target programmed");
    bus_wr(A_ERR, 8'h80);
    bus_wr(A_STAT, 8'h02);
  endtask

  task automatic t_regs;
    int n; logic [7:0] st;
    bus_wr(A_STATM, 8'hFF);
    expect_rd(A_STATM, 8'h03, "R13 status mask bits");
    bus_wr(A_EMASK, 8'hFF);
    expect_rd(A_EMASK, 8'hFE, "R13 error mask bits");
    bus_wr(A_FCTL, 8'hF0);
    expect_rd(A_FCTL, 8'hF0, "R13 control fields held");
    set_addr(0, 0, 7);
    run_op(8'hF1, n, st);
    chk(n == PRG_N, "R13 length field no effect", n, PRG_N);
    expect_rd(sh(0, 0), 8'h80, "R13 program ran");
    bus_wr(A_STAT, 8'h02);
    bus_wr(A_KEY, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_override();
    t_ovr_prot();
    t_rd_prot();
    t_w1c();
    t_program();
    t_sense();
    t_nokey();
    t_wprot();
    t_sns_prot();
    t_busy();
    t_regs();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule